// File: doc/BRIEF.md
# Multichannel SAR ADC Scan Sequencer

This block is the master side of a serial link to a sixteen-input successive-approximation converter. It drives chip select, the serial clock and the command line. It collects the 16-bit word that the converter returns in every frame. The command it sends selects the channels one after another, in a fixed round-robin order. Each returned word is published with a one-cycle strobe and the number of the channel it was converted from.

A frame holds exactly sixteen serial clock periods while chip select is low. The converter begins tracking its next input on the fourteenth rising clock edge of a frame and keeps tracking until chip select falls again. For this reason the sequencer does not start a frame as soon as the previous one ends. It waits until two limits are both met: a minimum spacing between chip-select falling edges, which caps the total rate at one million frames per second, and a minimum tracking window after that fourteenth edge. Both limits are parameters counted in system-clock cycles. The defaults assume a 100 MHz system clock: 100 cycles for the 1 µs spacing and 33 cycles for the 325 ns window.

The serial clock half-period comes from a run-time input, and values too small for a 20 MHz serial clock are raised to a floor. Because the converter answers with the conversion requested two frames earlier, the block keeps a short history of channel numbers so that each word carries the correct tag. When enable is cleared, the frame in progress runs to its end and no new frame starts.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A frame contains exactly 16 rising serial clock edges while cs_n is low. sclk is low whenever cs_n is high. cs_n returns high one half-period after the 16th falling edge of sclk.
- R2: Each sclk half-period lasts exactly max(half_div, MIN_HALF) system cycles (MIN_HALF = 3 by default, which gives a serial clock of at most 20 MHz at 100 MHz). The value is captured when cs_n falls.
- R3: Two successive falling edges of cs_n are never less than FRAME_CYC (default 100) system cycles apart.
- R4: cs_n never falls less than ACQ_CYC (default 33) system cycles after the 14th rising sclk edge of the previous frame.
- R5: With en held high and half_div unchanged, cs_n falls at the earliest allowed cycle. The spacing between falls is max(FRAME_CYC, 27·h + ACQ_CYC, 33·h + 1), where h is the effective half-period.
- R6: mosi carries a 16-bit command, MSB first. The first bit is present when cs_n falls and each later bit follows a falling sclk edge. Bits 15:12 are 4'b0001, bits 11:8 hold the channel, and bits 7:0 are zero. The channels run 0, 1, …, 15, 0, … from reset. mosi is low while cs_n is high.
- R7: miso is sampled on each rising sclk edge, MSB first. The 16-bit word appears on rd_data with rd_valid high for exactly one cycle, the cycle in which cs_n returns high.
- R8: rd_ch equals the channel commanded two frames earlier. rd_valid stays low for the first two frames after reset.
- R9: When en is low, the frame in progress completes normally and cs_n does not fall again while en remains low.
- R10: While reset is asserted and afterwards, until the first frame, cs_n is high and sclk, mosi and rd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Allows new frames to start |
| half_div | input | 8 | Requested serial clock half-period in system cycles |
| miso | input | 1 | Serial data returned by the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial command data |
| rd_valid | output | 1 | One-cycle strobe for a new result |
| rd_data | output | 16 | Result word |
| rd_ch | output | 4 | Channel the result belongs to |

## Verification
The timing assertions assume that the system clock rate matches the FRAME_CYC and ACQ_CYC settings. They also assume that reset is applied before the first frame, so that the spacing counters start from a known frame boundary. The stimulus changes half_div only while en is low and chip select is high. Otherwise the frame period would be exact only after the next frame has started. The modelled converter changes miso only after a falling sclk edge or a chip-select fall, several system cycles before the next rising edge, so each sampled bit is already stable.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int DW        = 16,
  parameter int NCH       = 16,
  parameter int HW        = 8,
  parameter int MIN_HALF  = 3,
  parameter int FRAME_CYC = 100,
  parameter int ACQ_CYC   = 33,
  parameter int ACQ_EDGE  = 14,
  parameter int LAT       = 2,
  parameter logic [3:0] CMD_HDR = 4'b0001
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [HW-1:0]           half_div,
  input  logic                    miso,
  output logic                    cs_n,
  output logic                    sclk,
  output logic                    mosi,
  output logic                    rd_valid,
  output logic [DW-1:0]           rd_data,
  output logic [$clog2(NCH)-1:0]  rd_ch
);

  localparam int CW   = $clog2(NCH);
  localparam int EW   = $clog2(2*DW+1);
  localparam int LIM  = (FRAME_CYC > ACQ_CYC) ? FRAME_CYC : ACQ_CYC;
  localparam int TW   = $clog2(LIM+1);
  localparam int FW   = $clog2(LAT+1);
  localparam int PADW = DW - 4 - CW;

  localparam logic [EW-1:0] E_LAST = EW'(2*DW);
  localparam logic [EW-1:0] E_ACQ  = EW'(2*(ACQ_EDGE-1));
  localparam logic [TW-1:0] T_LIM  = TW'(LIM);
  localparam logic [TW-1:0] T_FRM  = TW'(FRAME_CYC);
  localparam logic [TW-1:0] T_ACQ  = TW'(ACQ_CYC);
  localparam logic [HW-1:0] H_MIN  = HW'(MIN_HALF);
  localparam logic [FW-1:0] F_FULL = FW'(LAT);
  localparam logic [CW-1:0] C_LAST = CW'(NCH-1);

  logic            busy;
  logic [HW-1:0]   hcnt, hlat, hsel;
  logic [EW-1:0]   edges;
  logic [DW-1:0]   cmd_sr, rx, cmd_word;
  logic [CW-1:0]   ch_cur;
  logic [CW-1:0]   hist [LAT];
  logic [FW-1:0]   fill;
  logic [TW-1:0]   fcnt, acnt;
  logic            tick, last, go;

  assign hsel     = (half_div < H_MIN) ? H_MIN : half_div;
  assign tick     = busy && (hcnt == hlat - 1'b1);
  assign last     = tick && (edges == E_LAST);
  assign go       = !busy && en && (fcnt >= T_FRM) && (acnt >= T_ACQ);
  assign cmd_word = {CMD_HDR, ch_cur, {PADW{1'b0}}};
  assign mosi     = !cs_n && cmd_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      hcnt     <= '0;
      hlat     <= H_MIN;
      edges    <= '0;
      cmd_sr   <= '0;
      rx       <= '0;
      ch_cur   <= '0;
      fill     <= '0;
      fcnt     <= T_LIM;
      acnt     <= T_LIM;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_ch    <= '0;
      for (int i = 0; i < LAT; i++) hist[i] <= '0;
    end else begin
      rd_valid <= 1'b0;
      fcnt     <= (fcnt == T_LIM) ? T_LIM : fcnt + 1'b1;
      acnt     <= (acnt == T_LIM) ? T_LIM : acnt + 1'b1;
      if (go) begin
        busy   <= 1'b1;
        cs_n   <= 1'b0;
        hlat   <= hsel;
        hcnt   <= '0;
        edges  <= '0;
        cmd_sr <= cmd_word;
        fcnt   <= TW'(1);
      end else if (busy) begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (last) begin
          busy     <= 1'b0;
          cs_n     <= 1'b1;
          rd_valid <= (fill == F_FULL);
          rd_data  <= rx;
          rd_ch    <= hist[LAT-1];
          hist[0]  <= ch_cur;
          for (int i = 1; i < LAT; i++) hist[i] <= hist[i-1];
          ch_cur   <= (ch_cur == C_LAST) ? '0 : ch_cur + 1'b1;
          if (fill != F_FULL) fill <= fill + 1'b1;
        end else if (tick) begin
          edges <= edges + 1'b1;
          if (!edges[0]) begin
            sclk <= 1'b1;
            rx   <= {rx[DW-2:0], miso};
            if (edges == E_ACQ) acnt <= TW'(1);
          end else begin
            sclk   <= 1'b0;
            cmd_sr <= {cmd_sr[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int FRAME_CYC = 100,
  parameter int ACQ_CYC   = 33,
  parameter int ACQ_EDGE  = 14,
  parameter int NRISE     = 16
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic rd_valid
);

  logic        pc, ps, seen, aseen;
  int unsigned gc, ac, rc;
  logic        fell, srise;

  assign fell  = pc && !cs_n;
  assign srise = sclk && !ps && !cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= 1'b1; ps <= 1'b0; seen <= 1'b0; aseen <= 1'b0;
      gc <= 0; ac <= 0; rc <= 0;
    end else begin
      pc <= cs_n;
      ps <= sclk;
      if (fell) begin gc <= 1; seen <= 1'b1; end
      else if (gc != 32'hFFFF_FFFF) gc <= gc + 1;
      if (srise && rc == ACQ_EDGE-1) begin ac <= 1; aseen <= 1'b1; end
      else if (ac != 32'hFFFF_FFFF) ac <= ac + 1;
      if (fell) rc <= 0;
      else if (srise) rc <= rc + 1;
    end
  end

  AST_SCLK_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R1
  AST_RISE_COUNT:  assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> rc == NRISE); // R1
  AST_FRAME_GAP:   assert property (@(posedge clk) disable iff (!rst_n) (seen && fell) |-> gc >= FRAME_CYC); // R3
  AST_ACQ_WINDOW:  assert property (@(posedge clk) disable iff (!rst_n) (aseen && fell) |-> ac >= ACQ_CYC); // R4
  AST_MOSI_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !mosi); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R7
  AST_VALID_AT_END:assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> $rose(cs_n)); // R7
  AST_HOLD_OFF:    assert property (@(posedge clk) disable iff (!rst_n) (cs_n && !en) |=> cs_n); // R9

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(
  .FRAME_CYC(FRAME_CYC), .ACQ_CYC(ACQ_CYC), .ACQ_EDGE(ACQ_EDGE), .NRISE(DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .rd_valid(rd_valid)
);

// File: tb/adc_scan_ctrl_test.sv
module adc_scan_ctrl_test;
  localparam int CLK_T = 10;
  localparam int FRM = 100;
  localparam int ACQ = 33;

  logic clk = 0, rst_n = 0, en = 0, miso = 0;
  logic [7:0] half_div = 0;
  logic cs_n, sclk, mosi, rd_valid;
  logic [15:0] rd_data;
  logic [3:0] rd_ch;

  adc_scan_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .half_div(half_div), .miso(miso),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ch(rd_ch)
  );

  always #(CLK_T/2) clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, fidx = 0, fall_t = 0, rise14_t = 0, sclk_t = 0, rises = 0, bitpos = 0;
  int hexp = 3;
  bit have_prev = 0, brk = 1, done = 0;
  logic pcs = 1, psc = 0;
  logic [15:0] cmd_rx;
  logic [15:0] words [0:1023];

  function automatic int exp_half(int h);
    return (h < 3) ? 3 : h;
  endfunction

  function automatic int exp_period(int h);
    int p;
    p = FRM;
    if (27*h + ACQ > p) p = 27*h + ACQ;
    if (33*h + 1 > p) p = 33*h + 1;
    return p;
  endfunction

  function automatic logic [15:0] exp_cmd(int k);
    return {4'b0001, 4'(k % 16), 8'h00};
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor and converter model
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (pcs && !cs_n) begin
          if (have_prev) begin
            chk(cyc - fall_t >= FRM, "R3 frame spacing", cyc - fall_t, FRM);
            chk(cyc - rise14_t >= ACQ, "R4 acquisition window", cyc - rise14_t, ACQ);
            if (!brk) chk(cyc - fall_t == exp_period(hexp), "R5 frame period", cyc - fall_t, exp_period(hexp));
          end
          have_prev = 1; brk = 0;
          fall_t = cyc; sclk_t = cyc; rises = 0; cmd_rx = '0;
          if (fidx < 1024) words[fidx] = 16'($urandom);
          miso = words[fidx % 1024][15];
          bitpos = 14;
          fidx++;
        end else if (!pcs && cs_n) begin
          int k;
          k = fidx - 1;
          chk(rises == 16, "R1 rising edges per frame", rises, 16);
          chk(cyc - sclk_t == hexp, "R1 tail half period", cyc - sclk_t, hexp);
          chk(cmd_rx == exp_cmd(k), "R6 command word", cmd_rx, exp_cmd(k));
          if (k >= 2) begin
            chk(rd_valid == 1, "R7 valid at frame end", rd_valid, 1);
            chk(rd_data == words[k % 1024], "R7 result data", rd_data, words[k % 1024]);
            chk(rd_ch == 4'((k - 2) % 16), "R8 channel tag", rd_ch, (k - 2) % 16);
          end else begin
            chk(rd_valid == 0, "R8 no valid while filling", rd_valid, 0);
          end
        end else if (!cs_n && sclk && !psc) begin
          chk(cyc - sclk_t == hexp, "R2 half period high", cyc - sclk_t, hexp);
          sclk_t = cyc; rises++;
          cmd_rx = {cmd_rx[14:0], mosi};
          if (rises == 14) rise14_t = cyc;
        end else if (!cs_n && !sclk && psc) begin
          chk(cyc - sclk_t == hexp, "R2 half period low", cyc - sclk_t, hexp);
          sclk_t = cyc;
          if (bitpos >= 0) miso = words[(fidx - 1) % 1024][bitpos];
          bitpos--;
        end
        if (cs_n && sclk) chk(0, "R1 sclk idle low", 1, 0);
        if (cs_n && mosi) chk(0, "R6 mosi idle low", 1, 0);
        if (rd_valid && !(!pcs && cs_n)) chk(0, "R7 stray valid", 1, 0);
      end
      pcs = cs_n; psc = sclk;
    end
  end

  task automatic wait_frames(int n);
    int target;
    target = fidx + n;
    while (fidx < target) @(negedge clk);
  endtask

  task automatic stop_and_hold();
    int n0;
    en = 0; brk = 1;
    @(negedge clk);
    while (!cs_n) @(negedge clk);
    n0 = fidx;
    repeat (300) @(negedge clk);
    chk(fidx == n0, "R9 no frame while disabled", fidx, n0);
    chk(cs_n == 1, "R9 cs held high", cs_n, 1);
  endtask

  task automatic run_with(int h, int nfr);
    half_div = 8'(h); hexp = exp_half(h); brk = 1;
    en = 1;
    wait_frames(nfr);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && rd_valid == 0, "R10 state in reset", {cs_n, sclk, mosi, rd_valid}, 4'b1000);
    rst_n = 1;
    repeat (40) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && rd_valid == 0 && fidx == 0, "R10 idle after reset", fidx, 0);
    // directed: clamped divider, then floor, then slow clock
    run_with(0, 20);
    stop_and_hold();
    run_with(1, 4);
    stop_and_hold();
    run_with(3, 5);
    en = 0; brk = 1;            // drop mid-frame shortly after a start
    wait (cs_n == 0);
    repeat (20) @(negedge clk);
    stop_and_hold();
    run_with(12, 4);
    stop_and_hold();
    // random phases
    for (int i = 0; i < 12; i++) begin
      run_with($urandom_range(0, 12), $urandom_range(2, 7));
      repeat ($urandom_range(0, 150)) @(negedge clk);
      stop_and_hold();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule